// File: doc/BRIEF.md
# PCIe Link Speed Bring-Up Sequencer

This block is the control state machine that brings a PCIe root-port link from reset to its best negotiated speed. On a start pulse it limits the controller's maximum-speed field to first generation, enables link training and waits for the link to report up. It then lifts the limit to second generation, requests a directed speed change, polls until the controller reports the change finished, confirms the link once more and reads the negotiated generation from the link status register.

All controller accesses go through a single register master port that carries one transaction at a time with a request/acknowledge handshake. Every change to a controller register is a read-modify-write: the write is issued only after the read data has returned. The link-up waits and the gap between polls come from one cycle counter, and their limits are parameters. The block ends in a done state that holds the generation, or in an error state. Either state lasts until the next start.

Top module: `link_speed_seq`

## Requirements
- R1: After reset, `reg_req`, `train_en`, `done` and `error` are 0 and `gen` is 0.
- R2: On `start`, the block reads offset 0x07C and writes it back with bits 3:0 set to 1 (first generation) and every other bit unchanged.
- R3: `train_en` rises only after the first-generation write of R2 has been acknowledged. It then stays high until the next accepted `start`.
- R4: If `link_up` does not assert within `LINK_WAIT_CYC` cycles of `train_en` rising, `error` asserts exactly `LINK_WAIT_CYC` cycles after that rise, and offset 0x80C is never accessed.
- R5: After the link is up, offset 0x07C is rewritten with bits 3:0 = 2 (second generation), all other bits kept. Offset 0x80C is then rewritten with bit 17 set and all other bits kept.
- R6: Offset 0x80C is re-read after the speed request until bit 17 reads 0, with at least `POLL_GAP` idle cycles between reads. After `MAX_POLLS` reads that all show bit 17 as 1, `error` asserts.
- R7: After the speed change completes, `link_up` is checked again with the same limit. A failure there asserts `error`, and the status register is not read.
- R8: On success, offset 0x080 is read, `gen` takes bits 19:16 of the read data, and `done` asserts.
- R9: Only one transaction is in flight. `reg_req` stays high with `reg_addr`, `reg_we` and `reg_wdata` stable until `reg_ack`.
- R10: `done` and `error` never assert together. Both hold until the next `start`, and a `start` that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence (accepted in idle, done or error) |
| link_up | input | 1 | Controller reports link up with training finished |
| train_en | output | 1 | Enables link training in the controller |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence failed (link wait or speed-change poll limit) |
| gen | output | 4 | Negotiated generation, valid when `done` |
| reg_req | output | 1 | Register transaction request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register byte offset |
| reg_wdata | output | DW | Write data |
| reg_ack | input | 1 | Transaction complete, one-cycle pulse |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |

## Verification
On every cycle, the assertions check the bus-holding rule and the exclusion of done and error. They also check that training never begins before a first-generation write has been acknowledged, that the speed-control register is touched only while training is enabled, and that the number of polls after a speed request stays within `MAX_POLLS`. Only the bench scenarios can show the following:
- the exact read-modify-write values;
- the precise cycle at which a link-up timeout fires;
- the poll count at the boundary where the 200th read clears;
- that a link lost after the speed change stops the status read;
- that a mid-run start leaves the outcome unchanged.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    // Controller register offsets (behaviour depends on them)
    localparam int unsigned OFS_LINK_CAP  = 32'h07C;
    localparam int unsigned OFS_LINK_STAT = 32'h080;
    localparam int unsigned OFS_SPD_CTL   = 32'h80C;

    // Field layout
    localparam int unsigned SPD_W        = 4;   // max-speed field at bits SPD_W-1:0
    localparam int unsigned SPD_GEN1     = 1;
    localparam int unsigned SPD_GEN2     = 2;
    localparam int unsigned CHG_BIT      = 17;  // directed speed change request/busy
    localparam int unsigned STAT_GEN_LSB = 16;  // negotiated generation, 4 bits
    localparam int unsigned GEN_W        = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_CAP1_RD, S_CAP1_WR, S_UP1, S_CAP2_RD, S_CAP2_WR,
        S_SPD_RD, S_SPD_WR, S_POLL_RD, S_POLL_GAP, S_UP2, S_STAT_RD,
        S_DONE, S_ERR
    } seq_state_e;
endpackage

// File: rtl/lsq_timer.sv
module lsq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != {CW{1'b1}})
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lsq_bus_port.sv
module lsq_bus_port #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_we,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_wdata,
    output logic          xfer_done,
    output logic [DW-1:0] xfer_rdata,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic          reg_ack,
    input  logic [DW-1:0] reg_rdata
);
    typedef struct packed {
        logic          active;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
        logic [DW-1:0] rdata;
    } port_t;

    port_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active && go) begin
            d.active = 1'b1;
            d.we     = go_we;
            d.addr   = go_addr;
            d.wdata  = go_wdata;
        end else if (q.active && reg_ack) begin
            d.active = 1'b0;
            d.done   = 1'b1;
            if (!q.we) d.rdata = reg_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_req    = q.active;
    assign reg_we     = q.we;
    assign reg_addr   = q.addr;
    assign reg_wdata  = q.wdata;
    assign xfer_done  = q.done;
    assign xfer_rdata = q.rdata;
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
    import lsq_pkg::*;
#(
    parameter int AW            = 12,
    parameter int DW            = 32,
    parameter int LINK_WAIT_CYC = 100000,
    parameter int POLL_GAP      = 500,
    parameter int MAX_POLLS     = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             link_up,
    output logic             train_en,
    output logic             done,
    output logic             error,
    output logic [GEN_W-1:0] gen,
    output logic             reg_req,
    output logic             reg_we,
    output logic [AW-1:0]    reg_addr,
    output logic [DW-1:0]    reg_wdata,
    input  logic             reg_ack,
    input  logic [DW-1:0]    reg_rdata
);
    localparam int TMAX = (LINK_WAIT_CYC > POLL_GAP) ? LINK_WAIT_CYC : POLL_GAP;
    localparam int CW   = $clog2(TMAX + 1) + 1;
    localparam int PW   = $clog2(MAX_POLLS + 1);
    localparam logic [DW-1:0] SPD_MASK = DW'((1 << SPD_W) - 1);
    localparam logic [DW-1:0] CHG_MASK = DW'(1) << CHG_BIT;

    typedef struct packed {
        seq_state_e       state;
        logic             pend;
        logic             train;
        logic [GEN_W-1:0] gen;
        logic [PW-1:0]    polls;
    } seq_t;

    seq_t d, q;

    logic          go, go_we, xfer_done, is_xact, xact_done, tclr;
    logic [AW-1:0] go_addr;
    logic [DW-1:0] go_wdata, rd;
    logic [CW-1:0] tcnt;

    lsq_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .xfer_done(xfer_done), .xfer_rdata(rd),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    lsq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .cnt(tcnt)
    );

    always_comb begin
        d         = q;
        go        = 1'b0;
        go_we     = 1'b0;
        go_addr   = '0;
        go_wdata  = '0;
        is_xact   = 1'b1;
        xact_done = 1'b0;

        // Command of each transaction state
        case (q.state)
            S_CAP1_RD, S_CAP2_RD: go_addr = AW'(OFS_LINK_CAP);
            S_CAP1_WR: begin
                go_we = 1'b1; go_addr = AW'(OFS_LINK_CAP);
                go_wdata = (rd & ~SPD_MASK) | DW'(SPD_GEN1);
            end
            S_CAP2_WR: begin
                go_we = 1'b1; go_addr = AW'(OFS_LINK_CAP);
                go_wdata = (rd & ~SPD_MASK) | DW'(SPD_GEN2);
            end
            S_SPD_RD, S_POLL_RD: go_addr = AW'(OFS_SPD_CTL);
            S_SPD_WR: begin
                go_we = 1'b1; go_addr = AW'(OFS_SPD_CTL);
                go_wdata = rd | CHG_MASK;
            end
            S_STAT_RD: go_addr = AW'(OFS_LINK_STAT);
            default:   is_xact = 1'b0;
        endcase

        // One transaction at a time: issue, then wait for completion
        if (is_xact) begin
            if (!q.pend) begin
                go     = 1'b1;
                d.pend = 1'b1;
            end else if (xfer_done) begin
                d.pend    = 1'b0;
                xact_done = 1'b1;
            end
        end

        case (q.state)
            S_IDLE, S_DONE, S_ERR: if (start) begin
                d.state = S_CAP1_RD;
                d.train = 1'b0;
                d.gen   = '0;
                d.polls = '0;
            end
            S_CAP1_RD: if (xact_done) d.state = S_CAP1_WR;
            S_CAP1_WR: if (xact_done) begin
                d.state = S_UP1;
                d.train = 1'b1;
            end
            S_UP1, S_UP2: begin
                if (link_up)
                    d.state = (q.state == S_UP1) ? S_CAP2_RD : S_STAT_RD;
                else if (tcnt == CW'(LINK_WAIT_CYC - 1))
                    d.state = S_ERR;
            end
            S_CAP2_RD: if (xact_done) d.state = S_CAP2_WR;
            S_CAP2_WR: if (xact_done) d.state = S_SPD_RD;
            S_SPD_RD:  if (xact_done) d.state = S_SPD_WR;
            S_SPD_WR:  if (xact_done) d.state = S_POLL_RD;
            S_POLL_RD: if (xact_done) begin
                if (!rd[CHG_BIT]) begin
                    d.state = S_UP2;
                end else begin
                    d.polls = q.polls + 1'b1;
                    d.state = (q.polls + 1'b1 == PW'(MAX_POLLS)) ? S_ERR : S_POLL_GAP;
                end
            end
            S_POLL_GAP: if (tcnt == CW'(POLL_GAP - 1)) d.state = S_POLL_RD;
            S_STAT_RD: if (xact_done) begin
                d.gen   = rd[STAT_GEN_LSB +: GEN_W];
                d.state = S_DONE;
            end
            default: d.state = S_IDLE;
        endcase

        tclr = (d.state != q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign train_en = q.train;
    assign done     = (q.state == S_DONE);
    assign error    = (q.state == S_ERR);
    assign gen      = q.gen;
endmodule

// File: rtl/link_speed_seq_chk.sv
module link_speed_seq_chk
    import lsq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int MAX_POLLS = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             train_en,
    input logic             done,
    input logic             error,
    input logic [GEN_W-1:0] gen,
    input logic             reg_req,
    input logic             reg_we,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic             reg_ack
);
    localparam int PCW = $clog2(MAX_POLLS + 2) + 1;

    logic           gen1_seen_q, train_prev_q;
    logic [PCW-1:0] polls_q;

    wire ctl_hit = reg_req && reg_ack && (reg_addr == AW'(OFS_SPD_CTL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen1_seen_q  <= 1'b0;
            train_prev_q <= 1'b0;
            polls_q      <= '0;
        end else begin
            train_prev_q <= train_en;
            if (train_prev_q && !train_en)
                gen1_seen_q <= 1'b0;
            else if (reg_req && reg_ack && reg_we && reg_addr == AW'(OFS_LINK_CAP)
                     && reg_wdata[SPD_W-1:0] == SPD_W'(SPD_GEN1))
                gen1_seen_q <= 1'b1;
            if (ctl_hit && reg_we)
                polls_q <= '0;
            else if (ctl_hit && polls_q != {PCW{1'b1}})
                polls_q <= polls_q + 1'b1;
        end
    end

    a_r3_train_after_gen1: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !train_prev_q) |-> gen1_seen_q);

    a_r4_ctl_only_when_training: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_addr == AW'(OFS_SPD_CTL)) |-> train_en);

    a_r6_poll_limit: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= PCW'(MAX_POLLS + 1));

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)
                                   && $stable(reg_wdata)));

    a_r10_done_error_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    a_r8_gen_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(gen)));
endmodule

bind link_speed_seq link_speed_seq_chk #(.AW(AW), .DW(DW), .MAX_POLLS(MAX_POLLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .train_en(train_en), .done(done),
    .error(error), .gen(gen), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
);

// File: tb/link_speed_seq_tb.sv
`timescale 1ns/1ps
module link_speed_seq_tb;
    localparam int AW = 12, DW = 32, LWAIT = 40, GAP = 3, MAXP = 200, LAT = 2;

    logic clk = 0, rst_n = 0, start = 0;
    logic train_en, done, error, reg_req, reg_we, reg_ack = 0;
    logic [3:0] gen;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata = '0;
    logic link_raw = 0, dropped = 0;
    wire  link_up = link_raw && !dropped;

    always #2.5 clk = ~clk;

    link_speed_seq #(.AW(AW), .DW(DW), .LINK_WAIT_CYC(LWAIT), .POLL_GAP(GAP),
                     .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
        .train_en(train_en), .done(done), .error(error), .gen(gen),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Controller model configuration and logs
    logic [31:0] cap_reg, ctl_reg, stat_reg;
    int busy_cfg, busy_left, up_delay, up_cnt;
    bit up_en, drop_on_spd, spd_written;
    int n_wr, poll_reads, ctl_access, stat_reads, hold_viol, lat_cnt;
    logic [AW-1:0] w_addr [8];
    logic [31:0]   w_data [8];
    logic          w_train[8];
    logic [AW-1:0] seen_addr;
    logic [31:0]   seen_wdata;
    logic          seen_we, seen_valid;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Register slave: responds on falling edges
    always @(negedge clk) begin
        if (reg_ack) begin
            reg_ack = 0;
            seen_valid = 0;
        end else if (reg_req) begin
            if (seen_valid && (seen_addr != reg_addr || seen_we != reg_we ||
                               seen_wdata != reg_wdata))
                hold_viol++;
            seen_valid = 1; seen_addr = reg_addr; seen_we = reg_we; seen_wdata = reg_wdata;
            if (lat_cnt < LAT) lat_cnt++;
            else begin
                lat_cnt = 0;
                if (reg_addr == 12'h80C) ctl_access++;
                if (reg_we) begin
                    if (n_wr < 8) begin
                        w_addr[n_wr] = reg_addr; w_data[n_wr] = reg_wdata; w_train[n_wr] = train_en;
                    end
                    n_wr++;
                    if (reg_addr == 12'h07C) cap_reg = reg_wdata;
                    if (reg_addr == 12'h80C) begin
                        ctl_reg = reg_wdata; busy_left = busy_cfg; spd_written = 1;
                        if (drop_on_spd) dropped = 1;
                    end
                end else begin
                    case (reg_addr)
                        12'h07C: reg_rdata = cap_reg;
                        12'h080: begin reg_rdata = stat_reg; stat_reads++; end
                        12'h80C: begin
                            reg_rdata = ctl_reg;
                            reg_rdata[17] = (busy_left > 0);
                            if (busy_left > 0) busy_left--;
                            if (spd_written) poll_reads++;
                        end
                        default: reg_rdata = 32'hDEAD_BEEF;
                    endcase
                end
                reg_ack = 1;
            end
        end
    end

    // Link partner model
    always @(negedge clk) begin
        if (!train_en) begin up_cnt = 0; link_raw = 0; end
        else if (up_en) begin
            if (up_cnt >= up_delay) link_raw = 1; else up_cnt++;
        end
    end

    task automatic setup(input logic [31:0] cap, input logic [31:0] ctl, input logic [31:0] st,
                         input int busy, input bit upe, input int updly, input bit drop);
        cap_reg = cap; ctl_reg = ctl; stat_reg = st; busy_cfg = busy; busy_left = 0;
        up_en = upe; up_delay = updly; drop_on_spd = drop; dropped = 0; spd_written = 0;
        n_wr = 0; poll_reads = 0; ctl_access = 0; stat_reads = 0; hold_viol = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_end();
        int k = 0;
        while (!done && !error && k < 5000) begin @(negedge clk); k++; end
        chk(k < 5000, "wait_end timeout", k, 5000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!reg_req && !train_en && !done && !error, "R1 idle outputs",
            {reg_req, train_en, done, error}, 0);
        chk(gen == 0, "R1 gen", gen, 0);
    endtask

    task automatic t_normal();
        setup(32'hA5C3_0F03, 32'h0001_0A5F, 32'h1232_0011, 3, 1, 5, 0);
        pulse_start();
        wait_end();
        chk(done && !error, "R8 done", {done, error}, 2'b10);
        chk(n_wr == 3, "R5 write count", n_wr, 3);
        chk(w_addr[0] == 12'h07C && w_data[0] == 32'hA5C3_0F01, "R2 gen1 write", w_data[0], 32'hA5C3_0F01);
        chk(w_train[0] == 0, "R3 train low at gen1 write", w_train[0], 0);
        chk(train_en == 1, "R3 train held", train_en, 1);
        chk(w_addr[1] == 12'h07C && w_data[1] == 32'hA5C3_0F02, "R5 gen2 write", w_data[1], 32'hA5C3_0F02);
        chk(w_addr[2] == 12'h80C && w_data[2] == 32'h0003_0A5F, "R5 speed request", w_data[2], 32'h0003_0A5F);
        chk(poll_reads == 4, "R6 poll count", poll_reads, 4);
        chk(gen == 4'h2, "R8 gen value", gen, 2);
        chk(hold_viol == 0, "R9 request held stable", hold_viol, 0);
        repeat (5) @(negedge clk);
        chk(done && !error && gen == 4'h2, "R10 done held", {done, error, gen}, 6'h22);
    endtask

    task automatic t_gen1_partner();
        setup(32'h0000_00FF, 32'hFFFD_FFFF, 32'h0001_0000, 0, 1, 0, 0);
        pulse_start();
        wait_end();
        chk(w_data[0] == 32'h0000_00F1, "R2 gen1 write high field", w_data[0], 32'h0000_00F1);
        chk(w_data[2] == 32'hFFFF_FFFF, "R5 speed request keeps bits", w_data[2], 32'hFFFF_FFFF);
        chk(poll_reads == 1, "R6 immediate clear", poll_reads, 1);
        chk(done && gen == 4'h1, "R8 gen1 result", gen, 1);
    endtask

    task automatic t_up_timeout();
        int n = 0;
        setup(32'h0000_0002, 32'h0, 32'h0002_0000, 0, 0, 0, 0);
        pulse_start();
        while (!train_en && n < 200) begin @(negedge clk); n++; end
        n = 0;
        while (!error && n < 500) begin @(negedge clk); n++; end
        chk(n == LWAIT, "R4 timeout cycle", n, LWAIT);
        chk(error && !done, "R4 error", {error, done}, 2'b10);
        chk(ctl_access == 0, "R4 no speed ctl access", ctl_access, 0);
        chk(gen == 0, "R4 gen cleared", gen, 0);
        repeat (4) @(negedge clk);
        chk(error, "R10 error held", error, 1);
    endtask

    task automatic t_poll_exhaust();
        setup(32'h0, 32'h0, 32'h0002_0000, 100000, 1, 2, 0);
        pulse_start();
        wait_end();
        chk(error && !done, "R6 exhaustion error", {error, done}, 2'b10);
        chk(poll_reads == MAXP, "R6 poll reads at limit", poll_reads, MAXP);
        chk(stat_reads == 0, "R6 no status read", stat_reads, 0);
    endtask

    task automatic t_poll_boundary();
        setup(32'h0, 32'h0, 32'h0002_0000, MAXP - 1, 1, 2, 0);
        pulse_start();
        wait_end();
        chk(done && !error, "R6 last poll clears", {done, error}, 2'b10);
        chk(poll_reads == MAXP, "R6 boundary poll count", poll_reads, MAXP);
    endtask

    task automatic t_recheck_fail();
        setup(32'h0, 32'h0, 32'h0002_0000, 2, 1, 1, 1);
        pulse_start();
        wait_end();
        chk(error && !done, "R7 recheck error", {error, done}, 2'b10);
        chk(n_wr == 3, "R7 speed request made", n_wr, 3);
        chk(stat_reads == 0, "R7 no status read", stat_reads, 0);
    endtask

    task automatic t_start_ignored();
        setup(32'h0000_0003, 32'h0, 32'h0002_0000, 2, 1, 10, 0);
        pulse_start();
        while (!train_en) @(negedge clk);
        pulse_start();
        wait_end();
        chk(done && n_wr == 3, "R10 mid-run start ignored", n_wr, 3);
        chk(gen == 4'h2, "R10 gen after ignored start", gen, 2);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        seen_valid = 0; lat_cnt = 0;
        setup(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_normal();
        t_gen1_partner();
        t_up_timeout();
        t_poll_exhaust();
        t_poll_boundary();
        t_recheck_fail();
        t_start_ignored();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule